// File: doc/BRIEF.md
# Write-Only I2C Command Receiver

This block listens on an I2C bus as a target that never returns data. It oversamples SCL and SDA with the system clock and finds START and STOP conditions. It compares the first byte after a START against its own 7-bit address with a write direction bit. On a match it acknowledges that byte and each byte after it by pulling SDA low for the ninth clock. It then gathers four payload bytes into a pending buffer.

The first payload byte carries a 4-bit function code in its upper nibble and a 4-bit multiplier in its lower nibble. The remaining three bytes build a 24-bit value, most significant byte first. The buffered command reaches the outputs only when a STOP follows the fifth acknowledged byte. A STOP that comes early, or a START that arrives before the closing STOP, drops the buffer and leaves the outputs unchanged. The only line the block drives is the SDA pull-down, through an output enable.

Top module: `cmd_i2c_sink`

## Requirements
- R1: While `rst` is high and after it falls, `sda_oe` and `cmd_valid` are 0 and `cmd_func`, `cmd_mult` and `cmd_value` are all zero.
- R2: An address byte equal to {DEV_ADDR, 1'b0}, sent MSB first, is acknowledged, and so is each of the four data bytes after it: `sda_oe` is 1 while SCL is high during the ninth clock of each byte.
- R3: An address byte that differs from {DEV_ADDR, 1'b0}, including the matching address with the direction bit set to 1, is not acknowledged. The block then acknowledges nothing and commits nothing until the next START.
- R4: Bit 7 of the first data byte is the MSB. Bits 7..4 of that byte become `cmd_func` and bits 3..0 become `cmd_mult`. Data bytes two, three and four become `cmd_value` bits 23..16, 15..8 and 7..0.
- R5: A command is committed only by a STOP after the fifth acknowledged byte. `cmd_valid` is then high for exactly one clock, in the same cycle the new fields appear.
- R6: A START that follows any number of acknowledged bytes without a STOP in between discards the pending bytes. No command is committed, and the frame that follows the START is received from its address byte.
- R7: A STOP after fewer than four data bytes, including after the address byte alone, commits nothing.
- R8: The device address is the parameter DEV_ADDR. Its default is 7'h60, and an overridden value is the address that gets matched.
- R9: `cmd_func`, `cmd_mult` and `cmd_value` keep their last committed values in every cycle in which `cmd_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High to pull SDA low (acknowledge) |
| cmd_valid | output | 1 | One-cycle strobe for a committed command |
| cmd_func | output | 4 | Committed function code |
| cmd_mult | output | 4 | Committed multiplier |
| cmd_value | output | 24 | Committed 24-bit value |

## Verification
The hardest case to reach is a frame whose five bytes were all acknowledged and that then ends in a START instead of a STOP. At that point the buffer is full and correct, and only the missing STOP keeps it off the outputs. The bench's bus master has a task that ends a frame with a START, both after the fifth byte and after the second data byte. It then sends a fresh complete frame and checks two things: that exactly one command appears, and that it carries only the second frame's payload. Before that, a sweep drives all 256 address bytes, each followed by STOP, to show that exactly one of them is acknowledged and that none commits.

// File: rtl/cmd_i2c_pkg.sv
package cmd_i2c_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK,
    ST_HOLD,
    ST_SKIP
  } sink_state_t;
endpackage

// File: rtl/cmd_i2c_sync.sv
module cmd_i2c_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d_i[l]};
    end
    assign q_o[l] = chain[STAGES-1];
  end
endmodule

// File: rtl/cmd_i2c_cond.sv
module cmd_i2c_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/cmd_i2c_ctrl.sv
module cmd_i2c_ctrl
  import cmd_i2c_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR   = 7'h60,
  parameter int unsigned       DATA_BYTES = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sda_s,
  input  logic                       scl_rise,
  input  logic                       scl_fall,
  input  logic                       start_det,
  input  logic                       stop_det,
  output logic                       ack_oe,
  output logic                       commit,
  output logic [DATA_BYTES*BYTE_W-1:0] pend
);
  localparam int unsigned PEND_W = DATA_BYTES * BYTE_W;
  localparam int unsigned IDX_W  = $clog2(DATA_BYTES + 1);
  localparam logic [BYTE_W-1:0] MATCH = {DEV_ADDR, 1'b0};

  sink_state_t       state;
  logic [3:0]        bit_cnt;
  logic [IDX_W-1:0]  byte_idx;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      byte_idx <= '0;
      shreg    <= '0;
      pend     <= '0;
      ack_oe   <= 1'b0;
      commit   <= 1'b0;
    end else begin
      commit <= 1'b0;
      if (start_det) begin
        state    <= ST_SHIFT;
        bit_cnt  <= '0;
        byte_idx <= '0;
        pend     <= '0;
        ack_oe   <= 1'b0;
      end else if (stop_det) begin
        if (state == ST_HOLD) commit <= 1'b1;
        state  <= ST_IDLE;
        ack_oe <= 1'b0;
      end else begin
        case (state)
          ST_SHIFT: begin
            if (scl_rise && bit_cnt != 4'd8) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && bit_cnt == 4'd8) begin
              if (byte_idx == '0 && shreg != MATCH) begin
                state <= ST_SKIP;
              end else begin
                ack_oe <= 1'b1;
                state  <= ST_ACK;
                if (byte_idx != '0) pend <= {pend[PEND_W-BYTE_W-1:0], shreg};
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              ack_oe  <= 1'b0;
              bit_cnt <= '0;
              if (byte_idx == IDX_W'(DATA_BYTES)) begin
                state <= ST_HOLD;
              end else begin
                byte_idx <= byte_idx + 1'b1;
                state    <= ST_SHIFT;
              end
            end
          end
          default: state <= state;
        endcase
      end
    end
  end
endmodule

// File: rtl/cmd_i2c_sink.sv
module cmd_i2c_sink
  import cmd_i2c_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h60,
  parameter int unsigned       SYNC_STAGES = 2,
  parameter int unsigned       FUNC_W      = 4,
  parameter int unsigned       MULT_W      = 4,
  parameter int unsigned       VAL_BYTES   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe,
  output logic                      cmd_valid,
  output logic [FUNC_W-1:0]         cmd_func,
  output logic [MULT_W-1:0]         cmd_mult,
  output logic [VAL_BYTES*BYTE_W-1:0] cmd_value
);
  localparam int unsigned VAL_W      = VAL_BYTES * BYTE_W;
  localparam int unsigned CMD_W      = FUNC_W + MULT_W + VAL_W;
  localparam int unsigned DATA_BYTES = CMD_W / BYTE_W;

  logic [1:0]       sync_q;
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, start_det, stop_det;
  logic             commit;
  logic [CMD_W-1:0] pend;

  cmd_i2c_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o (sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  cmd_i2c_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cmd_i2c_ctrl #(.DEV_ADDR(DEV_ADDR), .DATA_BYTES(DATA_BYTES)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .ack_oe    (sda_oe),
    .commit    (commit),
    .pend      (pend)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_func  <= '0;
      cmd_mult  <= '0;
      cmd_value <= '0;
    end else begin
      cmd_valid <= commit;
      if (commit) begin
        cmd_func  <= pend[CMD_W-1 -: FUNC_W];
        cmd_mult  <= pend[VAL_W +: MULT_W];
        cmd_value <= pend[VAL_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cmd_i2c_checks.sv
module cmd_i2c_checks #(
  parameter int unsigned CMD_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe,
  input logic             cmd_valid,
  input logic [CMD_W-1:0] cmd_all,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det
);
  // R5: the strobe lasts one cycle
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  // R5: a commit is always preceded by a detected STOP
  p_commit_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(stop_det, 2));

  // R9: fields move only together with the strobe
  p_hold_fields_r9: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> $stable(cmd_all));

  // R2: the pull-down starts only while SCL is low
  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R6: a START releases the data line
  p_start_release_r6: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_oe);

  // R5: no acknowledge in the commit cycle
  p_no_ack_commit_r5: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !sda_oe);
endmodule

bind cmd_i2c_sink cmd_i2c_checks #(.CMD_W(FUNC_W + MULT_W + VAL_BYTES * 8)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .sda_oe    (sda_oe),
  .cmd_valid (cmd_valid),
  .cmd_all   ({cmd_func, cmd_mult, cmd_value}),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det)
);

// File: tb/tb_cmd_i2c_sink.sv
module tb_cmd_i2c_sink;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 6;
  localparam int WATCHDOG   = 190000;
  localparam logic [6:0] TB_ADDR = 7'h2D;
  localparam logic [7:0] WR_BYTE = {TB_ADDR, 1'b0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_bus;
  logic sda_oe, cmd_valid;
  logic [3:0]  cmd_func, cmd_mult;
  logic [23:0] cmd_value;

  int n_chk = 0, n_fail = 0, n_commit = 0, n_wide = 0;
  bit prev_valid = 1'b0;
  logic [31:0] last_cmd = '0;
  bit last_ack;
  int acks;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  cmd_i2c_sink #(.DEV_ADDR(TB_ADDR)) dut (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe(sda_oe), .cmd_valid(cmd_valid), .cmd_func(cmd_func),
    .cmd_mult(cmd_mult), .cmd_value(cmd_value)
  );

  always @(negedge clk) begin
    if (cmd_valid) n_commit++;
    if (cmd_valid && prev_valid) n_wide++;
    prev_valid = cmd_valid;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    m_sda = 1'b0; wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(1);
    m_scl = 1'b1; wq(1);
    m_sda = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(1);
      m_scl = 1'b1; wq(2);
      m_scl = 1'b0; wq(1);
    end
    m_sda = 1'b1; wq(1);
    m_scl = 1'b1; wq(1);
    last_ack = (sda_bus == 1'b0);
    if (last_ack) acks++;
    wq(1);
    m_scl = 1'b0; wq(1);
  endtask

  // sends address and the first nbytes of payload (MSB byte first)
  task automatic send_frame(input logic [7:0] ab, input logic [31:0] pl, input int nbytes);
    acks = 0;
    bus_start();
    send_byte(ab);
    for (int k = 0; k < nbytes; k++) send_byte(pl[31 - 8*k -: 8]);
  endtask

  function automatic logic [31:0] cur_cmd();
    return {cmd_func, cmd_mult, cmd_value};
  endfunction

  task automatic full_ok(input logic [31:0] pl, input string tag);
    int c0;
    c0 = n_commit;
    send_frame(WR_BYTE, pl, 4);
    chk(acks == 5, {tag, " R2 acks"}, acks, 5);
    chk(n_commit == c0, {tag, " R5 no commit before STOP"}, n_commit - c0, 0);
    bus_stop();
    chk(n_commit == c0 + 1, {tag, " R5 one commit"}, n_commit - c0, 1);
    chk(cur_cmd() == pl, {tag, " R4 fields"}, cur_cmd(), pl);
    last_cmd = pl;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int c0;
    logic [31:0] pl;
    repeat (4) @(negedge clk);
    chk({sda_oe, cmd_valid} == 2'b00 && cur_cmd() == 0, "R1 in reset", {sda_oe, cmd_valid, cur_cmd()}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk({sda_oe, cmd_valid} == 2'b00 && cur_cmd() == 0, "R1 after reset", {sda_oe, cmd_valid, cur_cmd()}, 0);

    // address sweep: R2 R3 R8, each ended by STOP so R7 too
    for (int a = 0; a < 256; a++) begin
      c0 = n_commit;
      send_frame(8'(a), 32'h0, 0);
      bus_stop();
      chk(last_ack == (8'(a) == WR_BYTE), "R8 R2 R3 address ack", 32'(last_ack), 32'(8'(a) == WR_BYTE));
      chk(n_commit == c0 && cur_cmd() == 0, "R7 address only", n_commit - c0, 0);
    end

    // full frames, arithmetic payloads: R4 R5
    full_ok(32'hFFFF_FFFF, "ones");
    full_ok(32'h0000_0000, "zeros");
    for (int k = 1; k <= 12; k++) begin
      pl = {4'(k), 4'(15 - k), 24'((k * 24'h0B3C5D) ^ 24'hA50F00)};
      full_ok(pl, "sweep");
    end
    full_ok(32'h5A_81_02_C3, "marker");

    // R3: wrong address / read bit, full length
    send_frame({TB_ADDR, 1'b1}, 32'h1234_5678, 4);
    chk(acks == 0, "R3 read bit no ack", acks, 0);
    c0 = n_commit; bus_stop();
    chk(n_commit == c0 && cur_cmd() == last_cmd, "R3 R9 read bit no commit", cur_cmd(), last_cmd);
    send_frame(WR_BYTE ^ 8'h02, 32'h8765_4321, 4);
    chk(acks == 0, "R3 mismatch no ack", acks, 0);
    c0 = n_commit; bus_stop();
    chk(n_commit == c0 && cur_cmd() == last_cmd, "R3 R9 mismatch no commit", cur_cmd(), last_cmd);

    // R7: short frame
    send_frame(WR_BYTE, 32'hDEAD_BEEF, 3);
    chk(acks == 4, "R7 short acks", acks, 4);
    c0 = n_commit; bus_stop();
    chk(n_commit == c0 && cur_cmd() == last_cmd, "R7 R9 short no commit", cur_cmd(), last_cmd);

    // R6: START after five bytes, then a clean frame
    c0 = n_commit;
    send_frame(WR_BYTE, 32'hCAFE_F00D, 4);
    chk(acks == 5, "R6 first frame acks", acks, 5);
    bus_start();
    chk(n_commit == c0 && cur_cmd() == last_cmd, "R6 restart no commit", cur_cmd(), last_cmd);
    wq(1);
    full_ok(32'h3C_11_22_33, "R6 after restart");

    // R6: START after two data bytes
    c0 = n_commit;
    send_frame(WR_BYTE, 32'h9988_7766, 2);
    bus_start();
    chk(n_commit == c0 && cur_cmd() == last_cmd, "R6 mid restart no commit", cur_cmd(), last_cmd);
    wq(1);
    full_ok(32'h7E_00_FF_01, "R6 after mid restart");

    chk(n_wide == 0, "R5 strobe width", n_wide, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule